// File: doc/BRIEF.md
# Idle Channel PCM Squelch

This block sits on the transmit side of a voice codec, between the companding encoder and the serial PCM shifter. A strobe marks each new 8-bit companded code word, one per 8 kHz frame. The block keeps count of how many frames in a row carried only the four smallest codes (plus or minus zero, plus or minus one). Once that run has lasted a full idle window (2000 frames, 250 ms at 8 kHz), it sends a steady positive-zero code in place of each further idle word. A steady output keeps the far-end decoder from seeing a sign bit and a least significant bit that flip on crosstalk.

The first code word that is not idle goes out unchanged, and the idle window starts again from zero. The squelch works only while its enable is high. A law select picks the line encoding. For A-law, every second bit is inverted (XOR 0x55). For mu-law, every bit is inverted. The same select also picks the positive-zero code the block inserts. For mu-law an optional rule also replaces an all-zero word, so that the line never carries a long run of zeros.

Top module: `pcm_idle_squelch`

## Requirements
- R1: After reset, `code_out` is 0xFF and the idle counter is empty. A reset in the middle of an idle run therefore means a full window of new idle frames must pass before squelch can engage.
- R2: The idle codes are 0xD5, 0x55, 0xD4 and 0x54 under A-law (`law_mu`=0), and 0xFF, 0x7F, 0xFE and 0x7E under mu-law (`law_mu`=1). All other codes are non-idle.
- R3: `code_out` takes the value for a frame on the clock edge that samples `frame_vld` high. It holds that value until the next frame, whatever `code_in` does in between.
- R4: With squelch enabled, the first IDLE_FRAMES (default 2000) idle frames of a run pass unchanged. Frame IDLE_FRAMES+1 and every later idle frame of the same run output positive zero: 0xD5 for A-law, 0xFF for mu-law.
- R5: A non-idle frame passes at once and restarts the run. The next IDLE_FRAMES idle frames then pass unchanged again.
- R6: With `squelch_en` low, every code passes unchanged (apart from R7), and each frame clears the idle counter.
- R7: With ZERO_SUPPRESS=1 (the default), a mu-law code of 0x00 goes out as 0x02. This holds whatever the state of the enable. An A-law 0x00 passes unchanged.
- R8: While squelch is engaged, any mix of the four idle codes gives the same constant positive-zero output.
- R9: Idle classification follows the selected law. 0xFF is non-idle under A-law, and 0xD5 is non-idle under mu-law.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| squelch_en | input | 1 | Enables idle squelch |
| frame_vld | input | 1 | One-cycle strobe marking a new code word |
| law_mu | input | 1 | 1 selects mu-law line encoding, 0 selects A-law |
| code_in | input | 8 | Companded code word from the encoder |
| code_out | output | 8 | Code word to transmit |

## Verification
Idle runs cycle through all four idle codes of a law. This shows that the classifier accepts sign and LSB changes, and the output after the window shows that they collapse to one code. Checks fall on frames exactly IDLE_FRAMES and IDLE_FRAMES+1 of each run, so an off-by-one in the window is caught. A single large code placed inside an engaged run separates release and restart from a counter that is only paused. Codes that are idle under one law but not the other, together with a reset or a low enable partway through a run, show that the counter clears where it should. The all-zero word is sent under both laws and with the enable both high and low.

// File: rtl/pcm_sq_pkg.sv
package pcm_sq_pkg;
    typedef logic [7:0] pcm_code_t;

    localparam pcm_code_t ALAW_INV_MASK = 8'h55;
    localparam pcm_code_t ALAW_POS_ZERO = 8'hD5;
    localparam pcm_code_t MU_POS_ZERO   = 8'hFF;
    localparam pcm_code_t MU_ZERO_SUB   = 8'h02;
    localparam pcm_code_t LINE_IDLE     = 8'hFF;

    typedef struct packed {
        pcm_code_t code;
    } out_state_t;
endpackage

// File: rtl/pcm_code_classify.sv
module pcm_code_classify
    import pcm_sq_pkg::*;
(
    input  pcm_code_t code,
    input  logic      law_mu,
    output logic      is_idle,
    output pcm_code_t pos_zero
);
    pcm_code_t sm;

    always_comb begin
        sm       = law_mu ? ~code : (code ^ ALAW_INV_MASK);
        is_idle  = (sm[6:1] == 6'd0);
        pos_zero = law_mu ? MU_POS_ZERO : ALAW_POS_ZERO;
    end
endmodule

// File: rtl/pcm_idle_timer.sv
module pcm_idle_timer #(
    parameter int IDLE_FRAMES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_vld,
    input  logic count_en,
    output logic full
);
    localparam int CW = $clog2(IDLE_FRAMES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_FRAMES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (frame_vld) begin
            if (!count_en)
                s_d.cnt = '0;
            else if (s_q.cnt != LIMIT)
                s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign full = (s_q.cnt == LIMIT);

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LIMIT);
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld && !count_en |=> s_q.cnt == '0);
    p_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> $stable(s_q.cnt));
endmodule

// File: rtl/pcm_idle_squelch.sv
module pcm_idle_squelch
    import pcm_sq_pkg::*;
#(
    parameter int IDLE_FRAMES   = 2000,
    parameter bit ZERO_SUPPRESS = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       squelch_en,
    input  logic       frame_vld,
    input  logic       law_mu,
    input  logic [7:0] code_in,
    output logic [7:0] code_out
);
    logic      is_idle;
    logic      win_full;
    pcm_code_t pos_zero;
    pcm_code_t pass_code;
    logic      force_pz;

    pcm_code_classify u_class (
        .code     (code_in),
        .law_mu   (law_mu),
        .is_idle  (is_idle),
        .pos_zero (pos_zero)
    );

    pcm_idle_timer #(.IDLE_FRAMES(IDLE_FRAMES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_vld (frame_vld),
        .count_en  (squelch_en && is_idle),
        .full      (win_full)
    );

    generate
        if (ZERO_SUPPRESS) begin : g_zs
            always_comb
                pass_code = (law_mu && code_in == 8'h00) ? MU_ZERO_SUB : code_in;
        end else begin : g_nozs
            always_comb pass_code = code_in;
        end
    endgenerate

    out_state_t s_d, s_q;

    always_comb begin
        force_pz = squelch_en && is_idle && win_full;
        s_d = s_q;
        if (frame_vld)
            s_d.code = force_pz ? pos_zero : pass_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.code <= LINE_IDLE;
        else        s_q <= s_d;
    end

    assign code_out = s_q.code;

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> $stable(code_out));
    p_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld && squelch_en && is_idle && win_full |=> code_out == $past(pos_zero));
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld && !is_idle && code_in != 8'h00 |=> code_out == $past(code_in));
    p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld && !squelch_en && code_in != 8'h00 |=> code_out == $past(code_in));
    p_mu_nozero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld && law_mu && code_in == 8'h00 && ZERO_SUPPRESS |=> code_out == MU_ZERO_SUB);
endmodule

// File: tb/tb_pcm_idle_squelch.sv
module tb_pcm_idle_squelch;
    localparam int IDLE = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       squelch_en = 1'b0;
    logic       frame_vld = 1'b0;
    logic       law_mu = 1'b0;
    logic [7:0] code_in = 8'h00;
    logic [7:0] code_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pcm_idle_squelch dut (
        .clk(clk), .rst_n(rst_n), .squelch_en(squelch_en), .frame_vld(frame_vld),
        .law_mu(law_mu), .code_in(code_in), .code_out(code_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] c, input logic mu, input logic en,
                        output logic [7:0] o);
        @(negedge clk);
        code_in = c; law_mu = mu; squelch_en = en; frame_vld = 1'b1;
        @(negedge clk);
        frame_vld = 1'b0;
        o = code_out;
    endtask

    function automatic logic [7:0] idle_code(input int i, input logic mu);
        logic [7:0] a[4] = '{8'h55, 8'hD4, 8'h54, 8'hD5};
        logic [7:0] m[4] = '{8'h7F, 8'hFE, 8'h7E, 8'hFF};
        return mu ? m[i % 4] : a[i % 4];
    endfunction

    // n idle frames, each expected to pass unchanged
    task automatic run_idle(input int n, input logic mu, input logic en, input string req);
        logic [7:0] o;
        for (int i = 0; i < n; i++) begin
            send(idle_code(i, mu), mu, en, o);
            chk(req, o, idle_code(i, mu));
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] o;
        do_reset();
        chk("R1 reset output", code_out, 8'hFF);
        run_idle(1500, 1'b0, 1'b1, "R1 pre-reset run");
        do_reset();
        chk("R1 output after second reset", code_out, 8'hFF);
        run_idle(IDLE, 1'b0, 1'b1, "R1 counter cleared by reset");
        send(8'h54, 1'b0, 1'b1, o);
        chk("R1 window after reset", o, 8'hD5);
    endtask

    task automatic t_alaw_squelch();
        logic [7:0] o;
        do_reset();
        run_idle(IDLE, 1'b0, 1'b1, "R4 R2 A-law window passes");
        for (int i = 0; i < 8; i++) begin
            send(idle_code(i, 1'b0), 1'b0, 1'b1, o);
            chk("R8 R4 A-law forced +0", o, 8'hD5);
        end
    endtask

    task automatic t_release();
        logic [7:0] o;
        send(8'h9A, 1'b0, 1'b1, o);
        chk("R5 non-idle passes", o, 8'h9A);
        run_idle(IDLE, 1'b0, 1'b1, "R5 window restarted");
        send(8'h55, 1'b0, 1'b1, o);
        chk("R5 forced after new window", o, 8'hD5);
    endtask

    task automatic t_mulaw();
        logic [7:0] o;
        do_reset();
        run_idle(IDLE, 1'b1, 1'b1, "R4 R2 mu-law window passes");
        send(8'h7E, 1'b1, 1'b1, o);
        chk("R4 mu-law forced +0", o, 8'hFF);
        send(8'h7F, 1'b1, 1'b1, o);
        chk("R8 mu-law -0 forced", o, 8'hFF);
        send(8'hD5, 1'b1, 1'b1, o);
        chk("R9 0xD5 non-idle under mu-law", o, 8'hD5);
    endtask

    task automatic t_classify();
        logic [7:0] o;
        do_reset();
        run_idle(IDLE, 1'b0, 1'b1, "R9 A-law fill");
        send(8'hFF, 1'b0, 1'b1, o);
        chk("R9 0xFF non-idle under A-law", o, 8'hFF);
        run_idle(IDLE, 1'b0, 1'b1, "R9 restarted by 0xFF");
        send(8'hD4, 1'b0, 1'b1, o);
        chk("R9 forced after window", o, 8'hD5);
    endtask

    task automatic t_enable_low();
        logic [7:0] o;
        do_reset();
        run_idle(IDLE + 100, 1'b0, 1'b0, "R6 enable low passes idle");
        send(8'h3C, 1'b0, 1'b0, o);
        chk("R6 enable low passes data", o, 8'h3C);
        run_idle(1500, 1'b0, 1'b1, "R6 partial run");
        run_idle(5, 1'b0, 1'b0, "R6 enable low mid-run");
        run_idle(IDLE, 1'b0, 1'b1, "R6 counter cleared by enable low");
        send(8'hD5, 1'b0, 1'b1, o);
        chk("R6 window completes", o, 8'hD5);
    endtask

    task automatic t_zero();
        logic [7:0] o;
        do_reset();
        send(8'h00, 1'b1, 1'b1, o);
        chk("R7 mu-law zero substituted", o, 8'h02);
        send(8'h00, 1'b1, 1'b0, o);
        chk("R7 mu-law zero enable low", o, 8'h02);
        send(8'h00, 1'b0, 1'b1, o);
        chk("R7 A-law zero passes", o, 8'h00);
    endtask

    task automatic t_hold();
        logic [7:0] o;
        send(8'h6B, 1'b0, 1'b1, o);
        chk("R3 output follows frame", o, 8'h6B);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            code_in = 8'h11 + 8'(i);
            law_mu = i[0];
            @(negedge clk);
            chk("R3 output held between frames", code_out, 8'h6B);
        end
    endtask

    initial begin
        t_reset();
        t_alaw_squelch();
        t_release();
        t_mulaw();
        t_classify();
        t_enable_low();
        t_zero();
        t_hold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule